// File: doc/BRIEF.md
# Built-in Self-Test Payload Error Checker

This block scores a link self-test. While a test enable level is held high and the receive side reports lock, every qualified payload word is checked against an expected pattern of all zeros. Any word that has at least one bit set counts as one error. A live pass flag drops on the first error. When the enable goes low, checking stops and the verdict of the run is frozen on a held flag. That flag keeps its value until the next test starts or a reset occurs.

A saturating count of errored words is kept and can be sampled through a one-register status read port. The length of a test depends only on how long the enable stays high. There is no internal timeout.

The controller has three states:
- `ST_IDLE` is the state after reset.
- `ST_RUN` is the state in which words are checked.
- `ST_HOLD` is the state in which the verdict is held after a run.

The transitions are:
- START: from `ST_IDLE` or `ST_HOLD` to `ST_RUN` when the enable is sampled high. It clears the count and sets both flags high.
- STOP: from `ST_RUN` to `ST_HOLD` when the enable is sampled low. It captures the live flag into the held flag.
- All other cases keep the current state.

Top module: `bist_word_checker`

## Requirements
- R1: After reset, pass_live and pass_final are 1, err_count is 0 and rd_data is 0.
- R2: At the first clock edge where test_en is sampled 1 while no test is running (START), err_count becomes 0 and both pass flags become 1. The word presented in that same cycle is not checked.
- R3: While a test is running, each edge where test_en=1, link_locked=1, rx_valid=1 and rx_data is nonzero adds 1 to err_count and drives pass_live to 0 after that edge.
- R4: Words that are all zero, or that arrive with link_locked=0 or rx_valid=0, change neither err_count nor pass_live.
- R5: During a run, pass_live never returns to 1 once it has dropped. Only START raises it again.
- R6: At the first edge where test_en is sampled 0 during a run (STOP), pass_final takes the value of pass_live. From then on, no word is checked.
- R7: Outside a run, pass_final, pass_live and err_count hold their values whatever the word inputs do, until START or reset.
- R8: err_count saturates at 255 (2^CNT_W-1) and never wraps.
- R9: An edge with rd_en=1 loads rd_data with the err_count value from before that edge. With rd_en=0, rd_data holds.
- R10: A run has no length limit: checking continues for as long as test_en stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Self-test enable level |
| link_locked | input | 1 | Receive link lock indication |
| rx_valid | input | 1 | Qualifies rx_data |
| rx_data | input | DATA_W | Received payload word |
| rd_en | input | 1 | Status read strobe |
| pass_live | output | 1 | Live pass flag, low once an error is seen |
| pass_final | output | 1 | Verdict held from the last completed run |
| err_count | output | CNT_W | Saturating count of errored words |
| rd_data | output | CNT_W | Status read data |

## Verification
The bench drives more than 300 errored words in a single run, so a counter that wraps would show a small value instead of 255. It sends the enable high again while the verdict is held. A design that skips the clear, or that checks the word in the START cycle, would carry a stale count or a stale low flag into the new run. Nonzero words are presented with lock or valid low, and also during hold. A checker that ignored the qualifiers, or kept comparing after STOP, would miscount or corrupt the held verdict. Long random runs with interleaved reads catch a flag that recovers within a run and a read port that returns the count from after the edge.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } bwc_state_e;
endpackage

// File: rtl/bwc_ctrl.sv
module bwc_ctrl
    import bwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic test_en,
    input  logic word_ok,
    input  logic word_bad,
    output logic start,
    output logic hit,
    output logic pass_live,
    output logic pass_final
);
    bwc_state_e state_q, state_d;
    logic stop;

    assign start = (state_q != ST_RUN) && test_en;
    assign stop  = (state_q == ST_RUN) && !test_en;
    assign hit   = (state_q == ST_RUN) && test_en && word_ok && word_bad;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (test_en)  state_d = ST_RUN;
            ST_RUN:  if (!test_en) state_d = ST_HOLD;
            ST_HOLD: if (test_en)  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_live  <= 1'b1;
            pass_final <= 1'b1;
        end else if (start) begin
            pass_live  <= 1'b1;
            pass_final <= 1'b1;
        end else if (stop) begin
            pass_final <= pass_live;
        end else if (hit) begin
            pass_live  <= 1'b0;
        end
    end

    AST_LIVE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_live && !start) |=> !pass_live); // R5
    AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !test_en) |=> $stable(pass_final) && $stable(pass_live)); // R7
    AST_STOP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> pass_final == $past(pass_live)); // R6
    AST_HIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !pass_live); // R3
endmodule

// File: rtl/bwc_err_cnt.sv
module bwc_err_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (clr)                    cnt <= '0;
        else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0); // R2
    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX); // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(cnt)); // R4
endmodule

// File: rtl/bist_word_checker.sv
module bist_word_checker #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              link_locked,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rd_en,
    output logic              pass_live,
    output logic              pass_final,
    output logic [CNT_W-1:0]  err_count,
    output logic [CNT_W-1:0]  rd_data
);
    logic word_ok, word_bad, start, hit;

    assign word_ok  = link_locked && rx_valid;
    assign word_bad = |rx_data;

    bwc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .word_ok    (word_ok),
        .word_bad   (word_bad),
        .start      (start),
        .hit        (hit),
        .pass_live  (pass_live),
        .pass_final (pass_final)
    );

    bwc_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .inc   (hit),
        .cnt   (err_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= err_count;
    end

    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_data == $past(err_count)); // R9
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R9
endmodule

// File: tb/sim_bist_word_checker.sv
module sim_bist_word_checker;
    localparam int DATA_W = 24;
    localparam int CNT_W  = 8;
    localparam int MAXC   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0, link_locked = 1'b0, rx_valid = 1'b0, rd_en = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic pass_live, pass_final;
    logic [CNT_W-1:0] err_count, rd_data;

    int total = 0, bad = 0;
    int m_run = 0, m_cnt = 0, m_free = 1, m_final = 1, m_rd = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bist_word_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .link_locked(link_locked),
        .rx_valid(rx_valid), .rx_data(rx_data), .rd_en(rd_en),
        .pass_live(pass_live), .pass_final(pass_final),
        .err_count(err_count), .rd_data(rd_data)
    );

    function automatic int sat_inc(int c);
        return (c >= MAXC) ? MAXC : c + 1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "pass_live", int'(pass_live), m_free);
        chk(tag, "pass_final", int'(pass_final), m_final);
        chk(tag, "err_count", int'(err_count), m_cnt);
        chk(tag, "rd_data", int'(rd_data), m_rd);
    endtask

    task automatic step(string tag, bit en, bit lk, bit vl, logic [DATA_W-1:0] d, bit rd);
        test_en = en; link_locked = lk; rx_valid = vl; rx_data = d; rd_en = rd;
        if (rd) m_rd = m_cnt;
        if (m_run == 0 && en) begin
            m_run = 1; m_cnt = 0; m_free = 1; m_final = 1;
        end else if (m_run == 1 && !en) begin
            m_run = 0; m_final = m_free;
        end else if (m_run == 1 && lk && vl && d != '0) begin
            m_cnt = sat_inc(m_cnt); m_free = 0;
        end
        @(posedge clk); #1;
        compare_all(tag);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare_all("R1");

        // R7: words before any run are ignored
        step("R7", 0, 1, 1, 24'h00ff00, 0);
        // R2: start; word in start cycle not checked
        step("R2", 1, 1, 1, 24'h000001, 0);
        step("R4", 1, 1, 1, 24'h000000, 0);
        step("R4", 1, 0, 1, 24'h800000, 0);
        step("R4", 1, 1, 0, 24'h800000, 0);
        step("R3", 1, 1, 1, 24'h000010, 1);
        step("R5", 1, 1, 1, 24'h000000, 1);
        step("R6", 0, 1, 1, 24'h0000ff, 0);
        step("R7", 0, 1, 1, 24'hffffff, 1);
        step("R7", 0, 1, 1, 24'h123456, 0);
        // R2: restart clears stale low flag and count
        step("R2", 1, 1, 1, 24'hffffff, 0);
        for (int i = 0; i < 20; i++) step("R4", 1, 1, 1, 24'h0, 0);
        step("R6", 0, 0, 0, 24'h0, 0);
        // R8: saturation in one long run
        step("R2", 1, 1, 1, 24'h0, 0);
        for (int i = 0; i < 300; i++) step("R8", 1, 1, 1, 24'h000100, (i % 50) == 0);
        step("R9", 1, 1, 1, 24'h000001, 1);
        step("R6", 0, 1, 1, 24'h1, 0);
        // R10: long random run with no internal timeout
        step("R2", 1, 1, 1, 24'h0, 0);
        for (int i = 0; i < 5000; i++) begin
            bit lk = ($urandom % 8) != 0;
            bit vl = ($urandom % 4) != 0;
            logic [DATA_W-1:0] d = (($urandom % 200) == 0) ? DATA_W'($urandom) : '0;
            step("R10", 1, lk, vl, d, ($urandom % 16) == 0);
        end
        // random mix of runs and holds
        for (int i = 0; i < 8000; i++) begin
            bit en = (i % 400) < 300;
            logic [DATA_W-1:0] d = (($urandom % 30) == 0) ? DATA_W'($urandom) : '0;
            step("R3", en, ($urandom % 6) != 0, ($urandom % 3) != 0, d, ($urandom % 10) == 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule